// File: doc/BRIEF.md
# Equalizer Adaptation Trigger Sequencer

This block starts a receiver decision-feedback equalizer adaptation run by driving a fixed series of register accesses over a memory-mapped master port. After a start pulse, it takes ownership of a shared configuration bus and waits for the grant. It then sets one control bit at each of two addresses by read-modify-write, which selects the adaptation control and arms the trigger. It hands the bus back to the calibration engine, waits for the grant again, and polls the self-clearing trigger bit until the adaptation reports that it has finished.

A static configuration input chooses how bus ownership is recognised. In one mode the grant is seen when waitrequest drops. In the other mode a status register is read until its grant bit clears. Every wait loop is bounded by a programmable miss limit. If the limit is exceeded, the run stops, an error flag is raised, and the flag stays set until the next accepted start.

Top module: `eq_adapt_seq`

## Requirements
- R1: While reset is asserted, busy_o, done_o and error_o are low and neither mm_read_o nor mm_write_o is asserted.
- R2: start_i is accepted only while busy_o is low, and busy_o is high from the cycle after acceptance. A start pulse while busy has no effect on the bus accesses or on the outputs. No bus command is issued while idle.
- R3: The first access of a run is a write of value 2 to address 0x000, which requests ownership.
- R4: With grant_by_status_i low, each grant wait begins one cycle after the ownership write's completion has been seen. It ends at the first clock edge with mm_waitrequest_i low, and no bus command is issued during the wait.
- R5: With grant_by_status_i high, each grant wait reads address 0x281 repeatedly until bit 2 of the returned data is 0.
- R6: After the first grant, the block reads address 0x149 and then writes it back with bit 4 set and every other bit unchanged.
- R7: Next, the block reads address 0x100 and then writes it back with bit 6 set and every other bit unchanged.
- R8: Next, the block writes value 3 to address 0x000 and repeats the grant wait of R4 or R5.
- R9: The block then reads address 0x100 until bit 6 reads 0. On the clock edge after that read completes, done_o pulses for one cycle, busy_o falls in the same cycle, and error_o stays low.
- R10: While mm_waitrequest_i is high, an issued command keeps its address, read, write and writedata unchanged. Read data is taken only from a transfer that completes with mm_waitrequest_i low. Read and write are never asserted together.
- R11: In any wait loop, each failed grant check or failed poll read counts one miss. A miss that occurs when poll_limit_i misses have already counted ends the run: error_o and done_o rise, busy_o falls, and error_o stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| grant_by_status_i | input | 1 | Static: 0 grant seen by waitrequest, 1 grant seen by status bit polling |
| poll_limit_i | input | TMO_W | Misses tolerated per wait loop |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | Sticky timeout flag |
| mm_address_o | output | ADDR_W | Master address |
| mm_read_o | output | 1 | Master read strobe |
| mm_write_o | output | 1 | Master write strobe |
| mm_writedata_o | output | DATA_W | Master write data |
| mm_readdata_i | input | DATA_W | Slave read data |
| mm_waitrequest_i | input | 1 | Slave stall |

## Verification
busy_o is due one edge after the edge that samples an accepted start. done_o and busy_o change one edge after the edge on which the final poll read completes. In the waitrequest mode, a grant miss is judged from the second edge after the ownership write completes. The bench model applies these delays edge by edge, from its own bus log and the slave state it drives, and compares busy_o, done_o and error_o at every falling edge. Each accepted transfer is also checked in order against the expected address, direction and merged data.

// File: rtl/eq_adapt_pkg.sv
`timescale 1ns/1ps
package eq_adapt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_GNT, ST_SEL_RD, ST_SEL_WR,
    ST_ARM_RD, ST_ARM_WR, ST_REL, ST_POLL
  } seq_st_e;

  localparam int unsigned ARB_ADDR  = 'h000;
  localparam int unsigned GNT_ADDR  = 'h281;
  localparam int unsigned SEL_ADDR  = 'h149;
  localparam int unsigned TRIG_ADDR = 'h100;
  localparam int unsigned GNT_BIT   = 2;
  localparam int unsigned SEL_BIT   = 4;
  localparam int unsigned TRIG_BIT  = 6;
  localparam int unsigned OWN_USER  = 2;
  localparam int unsigned OWN_CAL   = 3;
endpackage

// File: rtl/eqa_bus_xfer.sv
`timescale 1ns/1ps
// Single-outstanding master: command registered, held through waitrequest (R10)
module eqa_bus_xfer #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mm_address_o,
  output logic              mm_read_o,
  output logic              mm_write_o,
  output logic [DATA_W-1:0] mm_writedata_o,
  input  logic [DATA_W-1:0] mm_readdata_i,
  input  logic              mm_waitrequest_i
);
  logic active;
  assign active = mm_read_o | mm_write_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o          <= 1'b0;
      rdata_o        <= '0;
      mm_address_o   <= '0;
      mm_read_o      <= 1'b0;
      mm_write_o     <= 1'b0;
      mm_writedata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      if (!active) begin
        if (req_i) begin
          mm_address_o   <= req_addr_i;
          mm_writedata_o <= req_wdata_i;
          mm_write_o     <= req_we_i;
          mm_read_o      <= !req_we_i;
        end
      end else if (!mm_waitrequest_i) begin
        mm_read_o  <= 1'b0;
        mm_write_o <= 1'b0;
        ack_o      <= 1'b1;
        if (mm_read_o) rdata_o <= mm_readdata_i;
      end
    end
  end
endmodule

// File: rtl/eqa_poll_timer.sv
`timescale 1ns/1ps
// Miss counter for wait loops (R11)
module eqa_poll_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             miss_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = miss_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (miss_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eq_adapt_seq.sv
`timescale 1ns/1ps
module eq_adapt_seq
  import eq_adapt_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              grant_by_status_i,
  input  logic [TMO_W-1:0]  poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] mm_address_o,
  output logic              mm_read_o,
  output logic              mm_write_o,
  output logic [DATA_W-1:0] mm_writedata_o,
  input  logic [DATA_W-1:0] mm_readdata_i,
  input  logic              mm_waitrequest_i
);
  localparam logic [DATA_W-1:0] SEL_MASK  = DATA_W'(1) << SEL_BIT;
  localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;

  seq_st_e           state_q;
  logic              pend_q, rel_q, busy_q, done_q, err_q;
  logic              bus_st, req, req_we, ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rdata;
  logic              gnt_hit, gnt_miss, poll_hit, poll_miss;
  logic              miss, clr, expired;

  // Access decode per state (R3, R5-R9)
  always_comb begin
    bus_st    = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    unique case (state_q)
      ST_REQ:    begin bus_st = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(ARB_ADDR); req_wdata = DATA_W'(OWN_USER); end
      ST_GNT:    begin bus_st = grant_by_status_i; req_addr = ADDR_W'(GNT_ADDR); end
      ST_SEL_RD: begin bus_st = 1'b1; req_addr = ADDR_W'(SEL_ADDR); end
      ST_SEL_WR: begin bus_st = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(SEL_ADDR); req_wdata = rdata | SEL_MASK; end
      ST_ARM_RD: begin bus_st = 1'b1; req_addr = ADDR_W'(TRIG_ADDR); end
      ST_ARM_WR: begin bus_st = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(TRIG_ADDR); req_wdata = rdata | TRIG_MASK; end
      ST_REL:    begin bus_st = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(ARB_ADDR); req_wdata = DATA_W'(OWN_CAL); end
      ST_POLL:   begin bus_st = 1'b1; req_addr = ADDR_W'(TRIG_ADDR); end
      default:   ;
    endcase
  end

  assign req = bus_st && !pend_q;

  // Grant detection: waitrequest level or status bit (R4, R5)
  assign gnt_hit   = grant_by_status_i ? (ack && !rdata[GNT_BIT]) : !mm_waitrequest_i;
  assign gnt_miss  = grant_by_status_i ? (ack &&  rdata[GNT_BIT]) :  mm_waitrequest_i;
  assign poll_hit  = ack && !rdata[TRIG_BIT];
  assign poll_miss = ack &&  rdata[TRIG_BIT];

  assign miss = ((state_q == ST_GNT) && gnt_miss) || ((state_q == ST_POLL) && poll_miss);
  assign clr  = !((state_q == ST_GNT) || (state_q == ST_POLL)) || ((state_q == ST_GNT) && gnt_hit);

  eqa_bus_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_i            (req),
    .req_we_i         (req_we),
    .req_addr_i       (req_addr),
    .req_wdata_i      (req_wdata),
    .ack_o            (ack),
    .rdata_o          (rdata),
    .mm_address_o     (mm_address_o),
    .mm_read_o        (mm_read_o),
    .mm_write_o       (mm_write_o),
    .mm_writedata_o   (mm_writedata_o),
    .mm_readdata_i    (mm_readdata_i),
    .mm_waitrequest_i (mm_waitrequest_i)
  );

  eqa_poll_timer #(.CNT_W(TMO_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .miss_i    (miss),
    .limit_i   (poll_limit_i),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      rel_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req)      pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin  // R2
          busy_q  <= 1'b1;
          err_q   <= 1'b0;
          rel_q   <= 1'b0;
          state_q <= ST_REQ;
        end
        ST_REQ:    if (ack) state_q <= ST_GNT;
        ST_GNT: begin
          if (gnt_hit) state_q <= rel_q ? ST_POLL : ST_SEL_RD;
          else if (expired) begin  // R11
            state_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1;
          end
        end
        ST_SEL_RD: if (ack) state_q <= ST_SEL_WR;
        ST_SEL_WR: if (ack) state_q <= ST_ARM_RD;
        ST_ARM_RD: if (ack) state_q <= ST_ARM_WR;
        ST_ARM_WR: if (ack) state_q <= ST_REL;
        ST_REL: if (ack) begin
          rel_q   <= 1'b1;
          state_q <= ST_GNT;
        end
        ST_POLL: begin
          if (poll_hit) begin  // R9
            state_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
          end else if (expired) begin
            state_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/eq_adapt_seq_chk.sv
`timescale 1ns/1ps
module eq_adapt_seq_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] mm_address_o,
  input logic              mm_read_o,
  input logic              mm_write_o,
  input logic [DATA_W-1:0] mm_writedata_o,
  input logic              mm_waitrequest_i
);
  AST_HOLD_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o || mm_write_o) && mm_waitrequest_i |=>
      $stable(mm_address_o) && $stable(mm_read_o) && $stable(mm_write_o) && $stable(mm_writedata_o)); // R10
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_read_o && mm_write_o)); // R10
  AST_IDLE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mm_read_o && !mm_write_o); // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o); // R11
endmodule

bind eq_adapt_seq eq_adapt_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .start_i          (start_i),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .error_o          (error_o),
  .mm_address_o     (mm_address_o),
  .mm_read_o        (mm_read_o),
  .mm_write_o       (mm_write_o),
  .mm_writedata_o   (mm_writedata_o),
  .mm_waitrequest_i (mm_waitrequest_i)
);

// File: tb/eq_adapt_seq_tb_top.sv
`timescale 1ns/1ps
module eq_adapt_seq_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int TW = 16;
  localparam int HANG = 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic gmode = 1'b0;
  logic [TW-1:0] limit = '0;
  logic busy, done, err;
  logic [AW-1:0] addr;
  logic rd, wr, wait_s;
  logic [DW-1:0] wdata, rdata;

  always #10 clk = ~clk;

  eq_adapt_seq #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .grant_by_status_i(gmode),
    .poll_limit_i(limit), .busy_o(busy), .done_o(done), .error_o(err),
    .mm_address_o(addr), .mm_read_o(rd), .mm_write_o(wr), .mm_writedata_o(wdata),
    .mm_readdata_i(rdata), .mm_waitrequest_i(wait_s)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- slave model ----------------
  int grant_cfg = 2, stall_cfg = 0, adapt_cfg = 3;
  logic slv_clr = 1'b0;
  int grant_left, stall_left, adapt_left;
  logic [DW-1:0] r149, r100;
  logic cmd;
  assign cmd = rd | wr;
  assign wait_s = (!gmode && grant_left > 0) || (cmd && stall_left > 0);

  always_comb begin
    case (addr)
      10'h281: rdata = {29'b0, grant_left > 0, 2'b0};
      10'h149: rdata = r149;
      10'h100: rdata = r100;
      default: rdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n || slv_clr) begin
      grant_left <= 0; stall_left <= stall_cfg; adapt_left <= 0;
      r149 <= 32'hA5A5_0003; r100 <= 32'h1234_0081;
    end else begin
      if (grant_left > 0) grant_left <= grant_left - 1;
      if (adapt_left > 0) begin
        adapt_left <= adapt_left - 1;
        if (adapt_left == 1) r100[6] <= 1'b0;
      end
      if (cmd && wait_s) begin
        if (stall_left > 0) stall_left <= stall_left - 1;
      end else if (cmd) begin
        stall_left <= stall_cfg;
        if (wr) begin
          case (addr)
            10'h000: grant_left <= grant_cfg;
            10'h149: r149 <= wdata;
            10'h100: begin r100 <= wdata; if (wdata[6]) adapt_left <= adapt_cfg; end
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- reference model ----------------
  bit busy_m, done_m, err_m, fin_pend, fin_err, after_rel;
  int step, fails, g_phase;
  logic [DW-1:0] rmw_v;

  task automatic finish_m(input bit e);
    busy_m = 0; done_m = 1; err_m = e; step = 99; g_phase = 0;
  endtask

  task automatic go_wait();
    fails = 0;
    if (gmode) step = after_rel ? 7 : 1;
    else begin step = 10; g_phase = 1; end
  endtask

  task automatic miss_m();
    if (fails == int'(limit)) begin fin_pend = 1; fin_err = 1; step = 99; end
    else fails++;
  endtask

  task automatic txn(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] r);
    case (step)
      0: begin
        chk(we && a == 0 && d == 2, "R3 request write", {we, a, d}, {1'b1, 10'h000, 32'd2});
        after_rel = 0; go_wait();
      end
      1, 7: begin
        chk(!we && a == 10'h281, "R5 status poll read", {we, a}, {1'b0, 10'h281});
        if (r[2]) miss_m();
        else begin fails = 0; step = (step == 1) ? 2 : 8; end
      end
      2: begin chk(!we && a == 10'h149, "R6 select read", {we, a}, {1'b0, 10'h149}); rmw_v = r; step = 3; end
      3: begin chk(we && a == 10'h149 && d == (rmw_v | 32'h10), "R6 select write", {we, a, d}, {1'b1, 10'h149, rmw_v | 32'h10}); step = 4; end
      4: begin chk(!we && a == 10'h100, "R7 arm read", {we, a}, {1'b0, 10'h100}); rmw_v = r; step = 5; end
      5: begin chk(we && a == 10'h100 && d == (rmw_v | 32'h40), "R7 arm write", {we, a, d}, {1'b1, 10'h100, rmw_v | 32'h40}); step = 6; end
      6: begin
        chk(we && a == 0 && d == 3, "R8 release write", {we, a, d}, {1'b1, 10'h000, 32'd3});
        after_rel = 1; go_wait();
      end
      8: begin
        chk(!we && a == 10'h100, "R9 completion poll read", {we, a}, {1'b0, 10'h100});
        if (!r[6]) begin fin_pend = 1; fin_err = 0; step = 99; end
        else miss_m();
      end
      default: chk(1'b0, "R2 R4 unexpected bus access", {we, a, d}, 64'h0);
    endcase
  endtask

  bit hold_v;
  logic [AW-1:0] hold_a;
  logic hold_r, hold_w;
  logic [DW-1:0] hold_d;

  always @(posedge clk) begin
    bit busy_pre;
    cyc++;
    if (!rst_n) begin
      busy_m = 0; done_m = 0; err_m = 0; fin_pend = 0; step = 99; fails = 0; g_phase = 0; after_rel = 0;
      hold_v = 0;
    end else begin
      busy_pre = busy_m;
      done_m = 0;
      if (fin_pend) begin fin_pend = 0; finish_m(fin_err); end
      if (g_phase == 2) begin  // R4 grant judged from waitrequest
        if (!wait_s) begin g_phase = 0; fails = 0; step = after_rel ? 8 : 2; end
        else if (fails == int'(limit)) finish_m(1);
        else fails++;
      end else if (g_phase == 1) g_phase = 2;
      if (start && !busy_pre) begin busy_m = 1; err_m = 0; step = 0; end
      if (cmd && !wait_s) txn(wr, addr, wdata, rdata);
      if (cmd && wait_s) begin hold_v = 1; hold_a = addr; hold_r = rd; hold_w = wr; hold_d = wdata; end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !done && !err && !rd && !wr, "R1 reset state", {busy, done, err, rd, wr}, 64'h0);
    end else begin
      chk(busy == busy_m, "R2 busy", busy, busy_m);
      chk(done == done_m, "R9 done", done, done_m);
      chk(err == err_m, "R11 error", err, err_m);
      if (hold_v) begin
        chk(addr == hold_a && rd == hold_r && wr == hold_w && wdata == hold_d, "R10 command held",
            {rd, wr, addr, wdata}, {hold_r, hold_w, hold_a, hold_d});
        hold_v = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input bit m, input int g, input int s, input int a, input int lim,
                     input bit exp_err, input bit extra);
    @(negedge clk);
    slv_clr = 1; gmode = m; grant_cfg = g; stall_cfg = s; adapt_cfg = a; limit = TW'(lim);
    @(negedge clk);
    slv_clr = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R9 run finished", done, 1'b1);
    chk(err == exp_err, exp_err ? "R11 timeout flagged" : "R9 clean finish", err, exp_err);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 3, 0, 4, 50, 0, 1);      // waitrequest grant, extra start ignored (R2, R4)
    run(0, 5, 2, 3, 50, 0, 0);      // stalled commands (R10)
    run(1, 4, 1, 6, 50, 0, 0);      // status grant (R5)
    run(1, 3, 0, HANG, 3, 1, 0);    // completion never clears (R11)
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R11 error sticky while idle", err, 1'b1);
    run(1, 2, 0, 2, 50, 0, 0);      // start clears error (R11)
    run(0, HANG, 0, 2, 2, 1, 0);    // waitrequest grant never comes (R4 R11)
    run(1, HANG, 1, 2, 0, 1, 0);    // status grant never comes, zero limit (R5 R11)
    run(0, 1, 1, 1, 50, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule